// File: doc/BRIEF.md
# Jitter-Timing Ring-Oscillator Random Bit Source

This core turns the timing jitter of a free-running ring oscillator into a stream of random bits. A counter clocked by the oscillator marks off windows of N oscillator cycles, back to back. The system clock measures how long each window lasts, and the parity of that duration is the raw random bit. Phase noise builds up over the N cycles, so this parity is much less predictable than a direct sample of the oscillator.

The raw bits go through a pairwise debiasing stage. Each surviving bit is XORed with the synchronized oscillator level and then offered on a one-bit valid/ready port. The oscillator input is asynchronous and enters the system domain through two-flop synchronizers. A larger N gives a longer accumulation window, which helps when the system clock is slow. A watchdog flags an oscillator that has stopped.

Top module: `jitter_trng`

## Requirements
- R1: While `rst_n` is low, and just after it is released, `valid_o` and `alarm_o` are 0.
- R2: The oscillator-domain counter closes a window on every N-th rising edge of `ro_clk_i`. The third rising edge after reset release closes the first window. A `cycles_i` value below 2 acts as 2. The system domain registers the window close on the third `clk` rising edge after the closing oscillator edge. The raw bit is the parity of the number of `clk` cycles between two consecutive window closes.
- R3: After reset or after `enable_i` rises, the first window close only starts timing and yields no raw bit.
- R4: Raw bits are taken in non-overlapping pairs (first, second). The pair (0,1) yields 0, the pair (1,0) yields 1, and the pairs (0,0) and (1,1) yield nothing.
- R5: The emitted bit is the debiased bit XOR the oscillator level. That level is sampled by the first `clk` rising edge after the oscillator edge that closed the window.
- R6: While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `bit_o` stays unchanged. A `clk` edge with both high clears `valid_o`, unless a new bit loads on that same edge.
- R7: A window that closes while `valid_o` is high is discarded. Its raw bit does not enter the pairing stage, but the next window is still timed from that close.
- R8: While `enable_i` is low, no new bit is produced, a half-collected pair is dropped, priming is cleared and `alarm_o` is cleared. A bit that is already valid stays offered.
- R9: If 2^REF_W or more `clk` cycles pass with `enable_i` high and no window close, `alarm_o` goes high. It then stays high until `enable_i` goes low or reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| ro_clk_i | input | 1 | Free-running ring-oscillator output, asynchronous |
| enable_i | input | 1 | Run control for measurement and output |
| cycles_i | input | CNT_W | Window length N in oscillator cycles (changed only during reset) |
| ready_i | input | 1 | Consumer accepts the offered bit |
| valid_o | output | 1 | A random bit is offered |
| bit_o | output | 1 | Offered random bit |
| alarm_o | output | 1 | Oscillator appears stuck |

## Verification
The oscillator is driven with randomly varying half-periods, and the bench predicts every window's parity from the edge times. This checks the timing, the pairing and the XOR together.

A run with a constant oscillator period makes every window the same length. The pairing stage must then discard everything, which separates a working debiaser from one that passes raw bits through. A run with N=1 shows whether the minimum-length clamp is present, because without it the window flag never falls.

Sparse `ready_i` forces the hold and discard paths. An enable-off run followed by an enable-on run separates priming from normal operation. Stopping the oscillator exercises the watchdog and its clearing.

// File: rtl/jt_pkg.sv
`timescale 1ns/1ps
package jt_pkg;

  typedef enum logic [1:0] {
    VN_NONE = 2'd0,
    VN_ZERO = 2'd1,
    VN_ONE  = 2'd2
  } vn_res_e;

  // Pairwise debias decision: equal bits are dropped, else the first bit wins.
  function automatic vn_res_e vn_decode(input logic first_bit, input logic second_bit);
    if (first_bit == second_bit) return VN_NONE;
    return first_bit ? VN_ONE : VN_ZERO;
  endfunction

endpackage

// File: rtl/jt_osc_window.sv
`timescale 1ns/1ps
module jt_osc_window #(
  parameter int CNT_W = 8
) (
  input  logic             ro_clk_i,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] len_i,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

  logic [1:0]       rsync_q;
  logic             ro_rst_n;
  logic [CNT_W-1:0] len_eff;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;

  // reset release synchronized to the oscillator
  always_ff @(posedge ro_clk_i or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign ro_rst_n = rsync_q[1];

  always_comb begin
    len_eff = (len_i < MIN_LEN) ? MIN_LEN : len_i;
  end

  always_comb begin
    if (cnt_q == '0) begin
      cnt_d  = len_eff - CNT_W'(1);
      wrap_d = 1'b1;
    end else begin
      cnt_d  = cnt_q - CNT_W'(1);
      wrap_d = 1'b0;
    end
  end

  always_ff @(posedge ro_clk_i or negedge ro_rst_n) begin
    if (!ro_rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign wrap_o = wrap_q;

  // R2
  cnt_range_chk: assert property (@(posedge ro_clk_i) disable iff (!ro_rst_n)
    cnt_q < len_eff);

  // R2
  wrap_pulse_chk: assert property (@(posedge ro_clk_i) disable iff (!ro_rst_n)
    wrap_q |=> !wrap_q);

endmodule

// File: rtl/jt_sync.sv
`timescale 1ns/1ps
module jt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/jt_ref_timer.sv
`timescale 1ns/1ps
module jt_ref_timer #(
  parameter int REF_W = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic wrap_i,
  output logic meas_stb_o,
  output logic meas_bit_o,
  output logic alarm_o
);

  localparam logic [REF_W-1:0] REF_MAX = '1;

  logic             wrap_prev_q;
  logic             rise;
  logic [REF_W-1:0] ref_q, ref_d, ref_inc;
  logic             primed_q, primed_d;
  logic             alarm_q, alarm_d;
  logic             stb;

  assign rise = wrap_i & ~wrap_prev_q;

  always_comb begin
    ref_inc  = (ref_q == REF_MAX) ? ref_q : ref_q + REF_W'(1);
    ref_d    = ref_q;
    primed_d = primed_q;
    alarm_d  = alarm_q;
    stb      = 1'b0;
    if (!enable_i) begin
      ref_d    = '0;
      primed_d = 1'b0;
      alarm_d  = 1'b0;
    end else if (rise) begin
      ref_d    = '0;
      primed_d = 1'b1;
      stb      = primed_q;
    end else begin
      ref_d    = ref_inc;
      alarm_d  = alarm_q | (ref_q == REF_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_prev_q <= 1'b0;
      ref_q       <= '0;
      primed_q    <= 1'b0;
      alarm_q     <= 1'b0;
    end else begin
      wrap_prev_q <= wrap_i;
      ref_q       <= ref_d;
      primed_q    <= primed_d;
      alarm_q     <= alarm_d;
    end
  end

  assign meas_stb_o = stb;
  assign meas_bit_o = ref_inc[0];
  assign alarm_o    = alarm_q;

  // R8
  alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !alarm_o);

  // R9
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && enable_i) |=> alarm_o);

  // R2
  single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_stb_o |=> !meas_stb_o);

endmodule

// File: rtl/jt_vn_out.sv
`timescale 1ns/1ps
module jt_vn_out
  import jt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic meas_stb_i,
  input  logic meas_bit_i,
  input  logic lvl_i,
  input  logic ready_i,
  output logic valid_o,
  output logic bit_o
);

  logic    half_q, half_d;
  logic    have_q, have_d;
  logic    valid_q, valid_d;
  logic    bit_q, bit_d;
  vn_res_e res;

  always_comb begin
    half_d  = half_q;
    have_d  = have_q;
    valid_d = valid_q;
    bit_d   = bit_q;
    res     = VN_NONE;
    if (valid_q && ready_i) valid_d = 1'b0;
    if (!enable_i) begin
      have_d = 1'b0;
    end else if (meas_stb_i && !valid_q) begin
      if (!have_q) begin
        half_d = meas_bit_i;
        have_d = 1'b1;
      end else begin
        have_d = 1'b0;
        res    = vn_decode(half_q, meas_bit_i);
        if (res != VN_NONE) begin
          valid_d = 1'b1;
          bit_d   = (res == VN_ONE) ^ lvl_i;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      have_q  <= 1'b0;
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      half_q  <= half_d;
      have_q  <= have_d;
      valid_q <= valid_d;
      bit_q   <= bit_d;
    end
  end

  assign valid_o = valid_q;
  assign bit_o   = bit_q;

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(bit_q)));

  // R7
  stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> $stable(bit_q));

  // R4
  rise_needs_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(meas_stb_i));

endmodule

// File: rtl/jitter_trng.sv
`timescale 1ns/1ps
module jitter_trng #(
  parameter int CNT_W       = 8,
  parameter int REF_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ro_clk_i,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             bit_o,
  output logic             alarm_o
);

  localparam int XW = 2;

  logic [1:0]    srst_q;
  logic          sys_rst_n;
  logic          wrap_ro;
  logic [XW-1:0] x_sync;
  logic          meas_stb;
  logic          meas_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= '0;
    else        srst_q <= {srst_q[0], 1'b1};
  end
  assign sys_rst_n = srst_q[1];

  jt_osc_window #(.CNT_W(CNT_W)) u_win (
    .ro_clk_i (ro_clk_i),
    .rst_n    (rst_n),
    .len_i    (cycles_i),
    .wrap_o   (wrap_ro)
  );

  jt_sync #(.WIDTH(XW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .d_i   ({wrap_ro, ro_clk_i}),
    .q_o   (x_sync)
  );

  jt_ref_timer #(.REF_W(REF_W)) u_ref (
    .clk        (clk),
    .rst_n      (sys_rst_n),
    .enable_i   (enable_i),
    .wrap_i     (x_sync[1]),
    .meas_stb_o (meas_stb),
    .meas_bit_o (meas_bit),
    .alarm_o    (alarm_o)
  );

  jt_vn_out u_vn (
    .clk        (clk),
    .rst_n      (sys_rst_n),
    .enable_i   (enable_i),
    .meas_stb_i (meas_stb),
    .meas_bit_i (meas_bit),
    .lvl_i      (x_sync[0]),
    .ready_i    (ready_i),
    .valid_o    (valid_o),
    .bit_o      (bit_o)
  );

endmodule

// File: tb/jitter_trng_tb.sv
`timescale 1ns/1ps
module jitter_trng_tb;

  localparam int CNT_W = 8;
  localparam int REF_W = 8;

  logic clk;
  logic rst_n;
  logic ro_clk;
  logic enable;
  logic [CNT_W-1:0] cycles;
  logic ready;
  logic valid_o, bit_o, alarm_o;

  jitter_trng #(.CNT_W(CNT_W), .REF_W(REF_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ro_clk_i(ro_clk), .enable_i(enable),
    .cycles_i(cycles), .ready_i(ready),
    .valid_o(valid_o), .bit_o(bit_o), .alarm_o(alarm_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int ro_edges;
  int nlen;
  int det_q[$];
  int half_left;
  int fixed_half;
  bit jitter_on;
  bit ro_run;
  int rdy_mode;
  bit chk_alarm;
  int unsigned seed = 32'h1234_5678;
  string tag;

  bit m_valid, m_bit, m_primed, m_have, m_half;
  int m_last;
  bit lvl_p1, lvl_p2;
  int delivered, dropped;

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic step();
    bit cap, pend, lvl_now;
    int raw;
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R1 watchdog expired", cyc, 150000);
      finish_run();
    end
    lvl_now = ro_clk;
    if (!rst_n) begin
      m_valid = 0; m_primed = 0; m_have = 0;
    end else begin
      cap = (det_q.size() > 0 && det_q[0] == cyc);
      if (cap) void'(det_q.pop_front());
      pend = m_valid;
      if (m_valid && ready) begin m_valid = 0; delivered++; end
      if (!enable) begin
        m_primed = 0; m_have = 0;
      end else if (cap) begin
        if (!m_primed) begin
          m_primed = 1;
        end else begin
          raw = (cyc - m_last) & 1;
          if (pend) dropped++;
          else if (!m_have) begin m_half = raw[0]; m_have = 1; end
          else begin
            m_have = 0;
            if (m_half != raw[0]) begin m_valid = 1; m_bit = m_half ^ lvl_p2; end
          end
        end
        m_last = cyc;
      end
    end
    lvl_p2 = lvl_p1;
    lvl_p1 = lvl_now;
    chk(valid_o === m_valid, {tag, " R6 valid"}, int'(valid_o), int'(m_valid));
    if (m_valid) chk(bit_o === m_bit, {tag, " R5 bit"}, int'(bit_o), int'(m_bit));
    if (chk_alarm) chk(alarm_o === 1'b0, "R9 no alarm while running", int'(alarm_o), 0);
    case (rdy_mode)
      0: ready = 1'b1;
      default: ready = ((rnd() % 8) == 0);
    endcase
    if (ro_run) begin
      half_left--;
      if (half_left <= 0) begin
        ro_clk = ~ro_clk;
        if (ro_clk) begin
          ro_edges++;
          if (ro_edges >= 3 && ((ro_edges - 3) % nlen) == 0) det_q.push_back(cyc + 3);
        end
        half_left = jitter_on ? int'(1 + (rnd() % 4)) : fixed_half;
      end
    end
  endtask

  task automatic scenario(input int n, input bit jit, input int fh, input int rm,
                          input bit en, input int ncyc, input string t);
    tag = t;
    rst_n = 0; ro_run = 0; ro_clk = 0; ro_edges = 0; det_q.delete();
    cycles = CNT_W'(n); nlen = (n < 2) ? 2 : n;
    jitter_on = jit; fixed_half = fh; rdy_mode = rm; enable = en;
    delivered = 0; dropped = 0;
    repeat (3) step();
    chk(valid_o === 1'b0, "R1 valid in reset", int'(valid_o), 0);
    chk(alarm_o === 1'b0, "R1 alarm in reset", int'(alarm_o), 0);
    rst_n = 1;
    repeat (4) step();
    ro_run = 1; half_left = 1;
    repeat (ncyc) step();
  endtask

  initial begin
    rst_n = 0; ro_clk = 0; enable = 0; cycles = '0; ready = 1;
    ro_run = 0; chk_alarm = 1; rdy_mode = 0; jitter_on = 1; fixed_half = 3;
    tag = "init"; nlen = 2; ro_edges = 0; half_left = 1;
    m_last = 0; lvl_p1 = 0; lvl_p2 = 0;

    // R4: jittered windows, pairs produce output
    scenario(3, 1'b1, 3, 0, 1'b1, 4000, "R4 jitter N3");
    chk(delivered > 10, "R4 bits delivered", delivered, 11);

    // R2: N=1 acts as 2
    scenario(1, 1'b1, 3, 0, 1'b1, 3000, "R2 clamp N1");
    chk(delivered > 10, "R2 clamp yields bits", delivered, 11);

    // R6, R7: scarce ready, stalled windows dropped
    scenario(4, 1'b1, 3, 1, 1'b1, 5000, "R7 stall N4");
    chk(dropped > 0, "R7 windows dropped while pending", dropped, 1);
    chk(delivered > 3, "R6 bits delivered under stall", delivered, 4);

    // R4: constant period, all pairs equal, nothing emitted
    scenario(4, 1'b0, 3, 0, 1'b1, 3000, "R4 constant N4");
    chk(delivered == 0, "R4 equal pairs discarded", delivered, 0);

    // R8 then R3: disabled, then enabled without reset
    scenario(3, 1'b1, 3, 0, 1'b0, 1500, "R8 disabled");
    chk(delivered == 0, "R8 no output when disabled", delivered, 0);
    ro_run = 0;
    repeat (10) step();
    enable = 1; tag = "R3 enable";
    repeat (5) step();
    ro_run = 1; half_left = 1;
    repeat (2000) step();
    chk(delivered > 5, "R3 output after priming", delivered, 6);

    // R9: stopped oscillator raises alarm, cleared by enable low
    scenario(3, 1'b1, 3, 0, 1'b1, 500, "R9 alarm");
    ro_run = 0; chk_alarm = 0;
    repeat (300) step();
    chk(alarm_o === 1'b1, "R9 alarm raised", int'(alarm_o), 1);
    repeat (50) step();
    chk(alarm_o === 1'b1, "R9 alarm sticky", int'(alarm_o), 1);
    enable = 0;
    repeat (2) step();
    chk(alarm_o === 1'b0, "R8 alarm cleared by disable", int'(alarm_o), 0);
    chk_alarm = 1;

    finish_run();
  end

endmodule